// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Character Queue and Clear-to-Send Gating

This block turns bytes written into a 16-entry queue into start-stop serial characters on a single output line. Each character is one low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The character length (7 or 8 data bits), the parity mode (none, even, odd), the stop-bit count and the oversampling ratio (16 or 8 base ticks per bit) are static configuration inputs. They are changed only while the line is idle and the queue is empty. A one-cycle-wide `tick_i` pulse from an external rate divider sets the base tick.

Flow control is optional. When it is enabled, a new character starts only while the active-low clear-to-send input, after a two-stage synchroniser, reads low. A character that has already started always runs to its last stop bit. A break input holds the line low for as long as it stays high. The block exposes the queue fill level, a full flag, a level interrupt for an empty queue, and a sticky flag that records a write attempted while the queue was full.

Top module: `ser_tx_top`

## Requirements
- R1: The line idles high. A character is one low start bit, then the data bits with bit 0 first, then the stop bits at high level. A character starts only when the queue held at least one entry.
- R2: With `cfg_len7_i` = 1 a character carries 7 data bits (`wr_data_i[6:0]`) and bit 7 of the written byte is never sent. With `cfg_len7_i` = 0 it carries all 8 bits.
- R3: With `cfg_par_en_i` = 1 a parity bit follows the last data bit. With `cfg_par_odd_i` = 0 it equals the XOR of the sent data bits (even). With `cfg_par_odd_i` = 1 it equals the complement of that XOR (odd). With `cfg_par_en_i` = 0 no parity bit is sent.
- R4: `cfg_stop2_i` = 0 sends one stop bit and `cfg_stop2_i` = 1 sends two.
- R5: One bit lasts 16 ticks when `cfg_os8_i` = 0 and 8 ticks when it is 1. Within a back-to-back stream, consecutive start bits are exactly (1 + data bits + parity bit + stop bits) × ticks-per-bit ticks apart.
- R6: The queue holds up to 16 entries and sends them in write order. `fill_o` gives the number held (0 to 16) and `full_o` is high at 16 entries.
- R7: `empty_irq_o` is high exactly while `fill_o` is 0.
- R8: A write while the queue is full is dropped, leaves `fill_o` unchanged and sets `wr_ovf_o`. Only reset clears `wr_ovf_o`.
- R9: With `cfg_cts_en_i` = 1, a new character starts only while `cts_n_i` (after two clock stages) is low. Deasserting it mid-character does not cut that character short. With `cfg_cts_en_i` = 0, `cts_n_i` has no effect.
- R10: While `brk_i` is high, `txd_o` is low from the next clock on and no new character starts. After `brk_i` falls, the line stays high for at least one bit period before a character may start.
- R11: After reset `txd_o` = 1, `fill_o` = 0, `full_o` = 0, `empty_irq_o` = 1 and `wr_ovf_o` = 0.
- R12: When the queue is empty and no character is in progress, `txd_o` is high, unless a break is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick, one clock wide |
| cfg_len7_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit enable |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2_i | input | 1 | 1: two stop bits, 0: one |
| cfg_os8_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfg_cts_en_i | input | 1 | Clear-to-send gating enable |
| cts_n_i | input | 1 | Clear-to-send, active low, asynchronous |
| brk_i | input | 1 | Hold the line low (break) |
| wr_en_i | input | 1 | Queue write strobe |
| wr_data_i | input | 8 | Byte to queue |
| txd_o | output | 1 | Serial output line |
| fill_o | output | 5 | Number of queued entries |
| full_o | output | 1 | Queue full |
| empty_irq_o | output | 1 | Queue-empty interrupt (level) |
| wr_ovf_o | output | 1 | Sticky write-while-full flag |

## Verification
A corrupted shift register, parity accumulator or bit index shows on `txd_o` within the bit period it affects, and a receiver model in the bench that samples each bit at mid-period catches it. A counting error in the queue shows on `fill_o` one clock after the write or start that caused it. A lost or duplicated read pointer shows in the next character as a byte out of write order. A state machine stuck in one state shows as a missing start edge or a wrong start-to-start spacing, both within a frame time, and the bench measures that spacing against the configured frame length.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [2:0] {
        FR_IDLE  = 3'd0,
        FR_START = 3'd1,
        FR_DATA  = 3'd2,
        FR_PAR   = 3'd3,
        FR_STOP  = 3'd4,
        FR_HOLD  = 3'd5
    } fr_state_e;

endpackage

// File: rtl/ser_tx_sync.sv
module ser_tx_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = d_i;
        end else begin : g_multi
            assign chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       rd_en_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic                       ovf_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        d     = q;
        do_wr = wr_en_i && (q.cnt != CNT_W'(DEPTH));
        do_rd = rd_en_i && (q.cnt != '0);
        if (wr_en_i && !do_wr) d.ovf = 1'b1;
        if (do_wr) d.wptr = (q.wptr == PTR_W'(DEPTH-1)) ? '0 : q.wptr + 1'b1;
        if (do_rd) d.rptr = (q.rptr == PTR_W'(DEPTH-1)) ? '0 : q.rptr + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wptr] <= wr_data_i;
    end

    assign rd_data_o = mem[q.rptr];
    assign cnt_o     = q.cnt;
    assign empty_o   = (q.cnt == '0);
    assign full_o    = (q.cnt == CNT_W'(DEPTH));
    assign ovf_o     = q.ovf;

endmodule

// File: rtl/ser_tx_bittimer.sv
module ser_tx_bittimer #(
    parameter int unsigned OS_FULL = 16,
    parameter int unsigned OS_HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic half_i,
    input  logic clr_i,
    output logic bit_end_o
);

    localparam int unsigned TW = $clog2(OS_FULL);

    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] lim;
    logic          at_lim;

    always_comb begin
        lim       = half_i ? TW'(OS_HALF-1) : TW'(OS_FULL-1);
        at_lim    = (cnt_q >= lim);
        bit_end_o = tick_i && !clr_i && at_lim;
        cnt_d     = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (tick_i) cnt_d = at_lim ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ser_tx_framer.sv
module ser_tx_framer
    import ser_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_len7_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_stop2_i,
    input  logic              q_empty_i,
    input  logic [DATA_W-1:0] q_data_i,
    input  logic              send_ok_i,
    input  logic              brk_i,
    input  logic              bit_end_i,
    output logic              pop_o,
    output logic              tclr_o,
    output logic              line_o,
    output logic              busy_o
);

    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        fr_state_e         st;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic              par;
        logic              stop2nd;
    } fr_t;

    fr_t q, d;
    logic             can_go;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        d        = q;
        pop_o    = 1'b0;
        tclr_o   = 1'b0;
        can_go   = !q_empty_i && send_ok_i && !brk_i;
        last_idx = cfg_len7_i ? IDX_W'(DATA_W-2) : IDX_W'(DATA_W-1);
        case (q.st)
            FR_IDLE: begin
                tclr_o = 1'b1;
                if (brk_i) begin
                    d.st = FR_HOLD;
                end else if (can_go) begin
                    d.st  = FR_START;
                    d.sh  = q_data_i;
                    d.par = cfg_par_odd_i;
                    d.idx = '0;
                    pop_o = 1'b1;
                end
            end
            FR_START: begin
                if (bit_end_i) begin
                    d.st  = FR_DATA;
                    d.idx = '0;
                end
            end
            FR_DATA: begin
                if (bit_end_i) begin
                    d.par = q.par ^ q.sh[0];
                    d.sh  = q.sh >> 1;
                    if (q.idx == last_idx) begin
                        d.st      = cfg_par_en_i ? FR_PAR : FR_STOP;
                        d.stop2nd = 1'b0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            FR_PAR: begin
                if (bit_end_i) begin
                    d.st      = FR_STOP;
                    d.stop2nd = 1'b0;
                end
            end
            FR_STOP: begin
                if (bit_end_i) begin
                    if (cfg_stop2_i && !q.stop2nd) begin
                        d.stop2nd = 1'b1;
                    end else if (brk_i) begin
                        d.st = FR_HOLD;
                    end else if (can_go) begin
                        d.st  = FR_START;
                        d.sh  = q_data_i;
                        d.par = cfg_par_odd_i;
                        d.idx = '0;
                        pop_o = 1'b1;
                    end else begin
                        d.st = FR_IDLE;
                    end
                end
            end
            FR_HOLD: begin
                if (brk_i)          tclr_o = 1'b1;
                else if (bit_end_i) d.st   = FR_IDLE;
            end
            default: d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            FR_START: line_o = 1'b0;
            FR_DATA:  line_o = q.sh[0];
            FR_PAR:   line_o = q.par;
            default:  line_o = 1'b1;
        endcase
        busy_o = (q.st == FR_START) || (q.st == FR_DATA) ||
                 (q.st == FR_PAR)   || (q.st == FR_STOP);
    end

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned OS_FULL     = 16,
    parameter int unsigned OS_HALF     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       cfg_len7_i,
    input  logic                       cfg_par_en_i,
    input  logic                       cfg_par_odd_i,
    input  logic                       cfg_stop2_i,
    input  logic                       cfg_os8_i,
    input  logic                       cfg_cts_en_i,
    input  logic                       cts_n_i,
    input  logic                       brk_i,
    input  logic                       wr_en_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic                       txd_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o,
    output logic                       full_o,
    output logic                       empty_irq_o,
    output logic                       wr_ovf_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic              cts_n_s;
    logic              send_ok;
    logic              q_empty;
    logic [DATA_W-1:0] q_data;
    logic [CNT_W-1:0]  q_cnt;
    logic              frm_pop, frm_tclr, frm_line, frm_busy;
    logic              bit_end;
    logic              txd_q, txd_d;

    ser_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cts_n_i),
        .q_o   (cts_n_s)
    );

    assign send_ok = !cfg_cts_en_i || !cts_n_s;

    ser_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (frm_pop),
        .rd_data_o (q_data),
        .cnt_o     (q_cnt),
        .empty_o   (q_empty),
        .full_o    (full_o),
        .ovf_o     (wr_ovf_o)
    );

    ser_tx_bittimer #(.OS_FULL(OS_FULL), .OS_HALF(OS_HALF)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .half_i    (cfg_os8_i),
        .clr_i     (frm_tclr),
        .bit_end_o (bit_end)
    );

    ser_tx_framer #(.DATA_W(DATA_W)) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len7_i    (cfg_len7_i),
        .cfg_par_en_i  (cfg_par_en_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .cfg_stop2_i   (cfg_stop2_i),
        .q_empty_i     (q_empty),
        .q_data_i      (q_data),
        .send_ok_i     (send_ok),
        .brk_i         (brk_i),
        .bit_end_i     (bit_end),
        .pop_o         (frm_pop),
        .tclr_o        (frm_tclr),
        .line_o        (frm_line),
        .busy_o        (frm_busy)
    );

    always_comb begin
        txd_d = brk_i ? 1'b0 : frm_line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd_d;
    end

    assign txd_o       = txd_q;
    assign fill_o      = q_cnt;
    assign empty_irq_o = q_empty;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brk_i,
    input logic             wr_en_i,
    input logic             cfg_cts_en_i,
    input logic             cts_s_i,
    input logic             pop_i,
    input logic             busy_i,
    input logic             txd_i,
    input logic [CNT_W-1:0] fill_i,
    input logic             full_i,
    input logic             wr_ovf_i
);

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i <= CNT_W'(DEPTH)); // R6

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i == $past(fill_i)) || (fill_i == $past(fill_i) + 1'b1) ||
        (fill_i + 1'b1 == $past(fill_i))); // R6

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_i && wr_en_i && !pop_i) |=> (wr_ovf_i && $stable(fill_i))); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovf_i |=> wr_ovf_i); // R8

    AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> ($past(fill_i) != '0)); // R1

    AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_en_i && cts_s_i && !busy_i) |=> !busy_i); // R9

    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> !txd_i); // R10

    AST_BRK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !busy_i) |=> !busy_i); // R10

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !brk_i) |=> txd_i); // R12

endmodule

bind ser_tx_top ser_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .brk_i        (brk_i),
    .wr_en_i      (wr_en_i),
    .cfg_cts_en_i (cfg_cts_en_i),
    .cts_s_i      (cts_n_s),
    .pop_i        (frm_pop),
    .busy_i       (frm_busy),
    .txd_i        (txd_o),
    .fill_i       (fill_o),
    .full_i       (full_o),
    .wr_ovf_i     (wr_ovf_o)
);

// File: tb/tb_ser_tx_top.sv
module tb_ser_tx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       cfg_len7_i = 1'b0, cfg_par_en_i = 1'b0, cfg_par_odd_i = 1'b0;
    logic       cfg_stop2_i = 1'b0, cfg_os8_i = 1'b0, cfg_cts_en_i = 1'b0;
    logic       cts_n_i = 1'b0, brk_i = 1'b0, wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       txd_o, full_o, empty_irq_o, wr_ovf_o;
    logic [4:0] fill_o;

    always #10 clk = ~clk;

    ser_tx_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cfg_len7_i(cfg_len7_i), .cfg_par_en_i(cfg_par_en_i),
        .cfg_par_odd_i(cfg_par_odd_i), .cfg_stop2_i(cfg_stop2_i),
        .cfg_os8_i(cfg_os8_i), .cfg_cts_en_i(cfg_cts_en_i), .cts_n_i(cts_n_i),
        .brk_i(brk_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .txd_o(txd_o), .fill_o(fill_o), .full_o(full_o),
        .empty_irq_o(empty_irq_o), .wr_ovf_o(wr_ovf_o)
    );

    int checks = 0, fails = 0, cyc = 0;
    int cur_n = 16, cur_p = 1, tcnt = 0;
    bit done = 1'b0;
    bit rx_en = 1'b1;
    logic [7:0] exp_q [0:511];
    int exp_wr = 0, rx_cnt = 0, last_gap = 0, prev_edge = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tick_i = (tcnt == 0);
        tcnt   = (tcnt + 1 >= cur_p) ? 0 : tcnt + 1;
    end

    function automatic logic [7:0] exp_char(input logic [7:0] b, input bit len7);
        return len7 ? {1'b0, b[6:0]} : b;
    endfunction

    function automatic bit exp_par(input logic [7:0] v, input bit odd);
        return (^v) ^ odd;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Receiver model: detect falling edge, sample every bit at mid-period.
    initial begin : rx_model
        logic prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rx_en && prev && !txd_o) begin : frame
                logic [7:0] got, ex;
                bit start_ok, stop_ok;
                logic pbit;
                last_gap  = cyc - prev_edge;
                prev_edge = cyc;
                got = 8'h00;
                pbit = 1'b0;
                stop_ok = 1'b1;
                repeat ((cur_n / 2) * cur_p) @(negedge clk);
                start_ok = !txd_o;
                for (int i = 0; i < (cfg_len7_i ? 7 : 8); i++) begin
                    repeat (cur_n * cur_p) @(negedge clk);
                    got[i] = txd_o;
                end
                if (cfg_par_en_i) begin
                    repeat (cur_n * cur_p) @(negedge clk);
                    pbit = txd_o;
                end
                for (int s = 0; s < (cfg_stop2_i ? 2 : 1); s++) begin
                    repeat (cur_n * cur_p) @(negedge clk);
                    if (!txd_o) stop_ok = 1'b0;
                end
                ex = exp_char(exp_q[rx_cnt & 511], cfg_len7_i);
                chk(start_ok && got == ex, "R1/R2 start bit and LSB-first data", got, ex);
                if (cfg_par_en_i)
                    chk(pbit == exp_par(ex, cfg_par_odd_i), "R3 parity bit", pbit,
                        exp_par(ex, cfg_par_odd_i));
                chk(stop_ok, "R4 stop bits high", stop_ok, 1);
                rx_cnt++;
                prev = 1'b1;
            end else begin
                prev = txd_o;
            end
        end
    end

    task automatic wr(input logic [7:0] b, input bit acc);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = b;
        @(negedge clk);
        wr_en_i   = 1'b0;
        if (acc) begin
            exp_q[exp_wr & 511] = b;
            exp_wr++;
        end
    endtask

    task automatic setcfg(input bit l7, input bit pe, input bit po, input bit s2,
                          input bit o8, input int p);
        @(negedge clk);
        cfg_len7_i = l7; cfg_par_en_i = pe; cfg_par_odd_i = po;
        cfg_stop2_i = s2; cfg_os8_i = o8;
        cur_n = o8 ? 8 : 16;
        cur_p = p;
    endtask

    task automatic drain();
        int w;
        w = 0;
        while (rx_cnt < exp_wr && w < 60000) begin
            @(negedge clk);
            w++;
        end
        chk(rx_cnt == exp_wr, "R6 all queued characters sent", rx_cnt, exp_wr);
        repeat (cur_n * cur_p * 2) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc >= 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int base, w;
        bit hi_ok;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(txd_o == 1'b1, "R11 txd after reset", txd_o, 1);
        chk(fill_o == 5'd0 && full_o == 1'b0, "R11 fill/full after reset", fill_o, 0);
        chk(empty_irq_o == 1'b1 && wr_ovf_o == 1'b0, "R11 irq/ovf after reset",
            {empty_irq_o, wr_ovf_o}, 2);

        // Directed 8N1, 16x
        setcfg(0, 0, 0, 0, 0, 1);
        wr(8'hA5, 1);
        wr(8'h3C, 1);
        drain();
        chk(txd_o == 1'b1, "R12 idle high after drain", txd_o, 1);
        chk(empty_irq_o == 1'b1, "R7 irq with empty queue", empty_irq_o, 1);

        // R5 spacing, 8E2 at 8x, stream released by CTS
        setcfg(0, 1, 0, 1, 1, 1);
        cfg_cts_en_i = 1'b1; cts_n_i = 1'b1;
        wr(8'h81, 1); wr(8'h7E, 1); wr(8'hFF, 1);
        repeat (200) @(negedge clk);
        chk(fill_o == 5'd3, "R9 CTS holds queue", fill_o, 3);
        chk(txd_o == 1'b1, "R9 no start without CTS", txd_o, 1);
        chk(empty_irq_o == 1'b0, "R7 irq low while data queued", empty_irq_o, 0);
        cts_n_i = 1'b0;
        drain();
        chk(last_gap == 96, "R5 8x frame spacing 8E2", last_gap, 96);

        // 7O1 at 16x, bit 7 set in data must be ignored
        setcfg(1, 1, 1, 0, 0, 1);
        cts_n_i = 1'b1;
        wr(8'hC3, 1); wr(8'h80, 1); wr(8'hD5, 1);
        repeat (50) @(negedge clk);
        cts_n_i = 1'b0;
        drain();
        chk(last_gap == 160, "R5/R2 16x frame spacing 7O1", last_gap, 160);

        // CTS dropped mid-character: that character completes, next waits
        setcfg(0, 0, 0, 0, 1, 1);
        cts_n_i = 1'b1;
        base = rx_cnt;
        wr(8'h12, 1); wr(8'h34, 1); wr(8'h56, 1);
        cts_n_i = 1'b0;
        w = 0;
        while (txd_o && w < 1000) begin @(negedge clk); w++; end
        cts_n_i = 1'b1;
        w = 0;
        while (rx_cnt < base + 1 && w < 5000) begin @(negedge clk); w++; end
        repeat (cur_n * 15) @(negedge clk);
        chk(rx_cnt == base + 1, "R9 started character completes, next held", rx_cnt, base + 1);
        chk(fill_o == 5'd2, "R9 queue held after CTS drop", fill_o, 2);
        cts_n_i = 1'b0;
        drain();

        // Overflow: fill to 16, one extra write dropped
        cts_n_i = 1'b1;
        for (int k = 0; k < 16; k++) wr(8'($urandom), 1);
        chk(full_o == 1'b1 && fill_o == 5'd16, "R6 full at 16", fill_o, 16);
        chk(wr_ovf_o == 1'b0, "R8 no overflow before extra write", wr_ovf_o, 0);
        wr(8'hEE, 0);
        chk(fill_o == 5'd16, "R8 write to full queue ignored", fill_o, 16);
        chk(wr_ovf_o == 1'b1, "R8 overflow flag set", wr_ovf_o, 1);
        cts_n_i = 1'b0;
        drain();
        chk(wr_ovf_o == 1'b1, "R8 overflow flag sticky", wr_ovf_o, 1);
        cfg_cts_en_i = 1'b0;

        // Break
        setcfg(0, 0, 0, 0, 0, 1);
        rx_en = 1'b0;
        @(negedge clk);
        brk_i = 1'b1;
        @(negedge clk);
        chk(txd_o == 1'b0, "R10 break drives line low", txd_o, 0);
        wr(8'h69, 1); wr(8'h96, 1);
        repeat (300) @(negedge clk);
        chk(fill_o == 5'd2 && txd_o == 1'b0, "R10 no start during break", fill_o, 2);
        brk_i = 1'b0;
        hi_ok = 1'b1;
        for (int i = 0; i < cur_n - 1; i++) begin
            @(negedge clk);
            if (!txd_o) hi_ok = 1'b0;
        end
        chk(hi_ok, "R10 guard bit high after break", hi_ok, 1);
        rx_en = 1'b1;
        drain();

        // Random batches; CTS disabled with random cts_n (must be ignored)
        for (int b = 0; b < 14; b++) begin
            int n;
            setcfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1 + int'($urandom % 2));
            cfg_cts_en_i = 1'b0;
            cts_n_i = 1'($urandom);
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) begin
                wr(8'($urandom), 1);
                repeat ($urandom % 40) @(negedge clk);
            end
            drain();
            chk(fill_o == 5'd0 && txd_o == 1'b1, "R9/R12 CTS ignored, line idle", fill_o, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule